// File: doc/BRIEF.md
# Self-Synchronizing Scrambler with Seed Select

This block whitens or restores a serial bit stream for a spread-spectrum radio path, one bit per valid cycle. In transmit mode each payload bit is combined with two taps of a seven-stage delay line, and the resulting line bit is fed back into that line. In receive mode the same taps are used, but the received line bit is what enters the delay line. The receiver therefore falls into step with the transmitter after seven bits, whatever state it started from.

Two seven-bit seed registers are kept, one for frames with the long preamble and one for frames with the short preamble. A bank-select input decides which of the two is written and read back. A frame-start pulse copies one of them into the delay line, and the short-preamble flag chooses which. Certain periodic streams leave the delay line cycling in step with the data, so the line carries the data unscrambled. A detector watches the bit entering the delay line for four such periods and raises a lock-up flag once one of them has held long enough.

Top module: `selfsync_scrambler`

## Requirements
- R1: In transmit mode (mode_rx = 0) the output bit is the input bit XOR delay stage 4 XOR delay stage 7. That output bit enters stage 1 and every stage moves one place toward stage 7.
- R2: In receive mode (mode_rx = 1) the output uses the same two taps, but the received bit is what enters stage 1. From the eighth received bit onward the output equals the transmitter's original data, whatever the starting state.
- R3: out_valid is in_valid delayed by one clock, and out_bit is updated in the same cycle. While in_valid is low the delay line does not move and in_bit has no effect.
- R4: There are two seven-bit seed registers: bank_sel = 0 selects the long-preamble seed and bank_sel = 1 the short-preamble seed. A pulse on seed_we writes seed_wdata into the selected register only.
- R5: seed_rdata shows the register chosen by bank_sel, without a clock of delay. After reset the long seed is 0x6C and the short seed is 0x1B.
- R6: A frame_start pulse loads the delay line from the short seed when short_pre = 1, otherwise from the long seed. Seed bit k goes to delay stage k+1, and stage 1 holds the most recent bit.
- R7: When frame_start and in_valid are high in the same cycle, that bit is processed against the freshly loaded seed, not the old line contents.
- R8: For each period p of 1, 2, 4 and 6, a run counter counts consecutive valid bits whose line bit equals delay stage p. lock_flag rises on the 64th such consecutive match of any period, and a mismatch resets that period's run.
- R9: frame_start clears all run counters, so lock_flag is low in the cycle after a frame_start pulse without in_valid.
- R10: After reset the delay line is all zeros and out_valid, out_bit and lock_flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rx | input | 1 | 0 scrambles (transmit), 1 descrambles (receive) |
| frame_start | input | 1 | Pulse that loads a seed into the delay line |
| short_pre | input | 1 | Selects the short-preamble seed at frame_start |
| bank_sel | input | 1 | Seed register selected for write and read-back |
| seed_we | input | 1 | Write strobe for the selected seed register |
| seed_wdata | input | 7 | Seed value to write |
| seed_rdata | output | 7 | Contents of the selected seed register |
| in_valid | input | 1 | in_bit carries a bit this cycle |
| in_bit | input | 1 | Payload bit (transmit) or line bit (receive) |
| out_valid | output | 1 | out_bit carries a bit |
| out_bit | output | 1 | Scrambled or descrambled bit |
| lock_flag | output | 1 | A repetitive pattern has held for the lock run length |

## Verification
The assertions assume that frame_start is a single-cycle pulse, that mode_rx only changes between frames while no bit is valid, and that in_bit is a known value whenever in_valid is high. The stimulus changes inputs only one time unit after the rising edge. It sets the direction and seeds before each scenario's frame_start, and drives in_valid only from the per-bit task, so these conditions hold throughout. Seed writes may coincide with bit traffic, and the bank-isolation properties are written to hold in that case too.

// File: rtl/sss_pkg.sv
`timescale 1ns/1ps
package sss_pkg;
  localparam int STAGES  = 7;
  localparam int TAP_A   = 4;
  localparam int TAP_B   = 7;
  localparam int NUM_PER = 4;
  localparam int PERIODS [NUM_PER] = '{1, 2, 4, 6};

  // bit i of a state holds delay stage i+1; stage 1 is the newest bit
  typedef logic [STAGES-1:0] state_t;

  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;

  function automatic logic key_bit(input state_t s);
    return s[TAP_A-1] ^ s[TAP_B-1];
  endfunction

  function automatic state_t push(input state_t s, input logic b);
    return {s[STAGES-2:0], b};
  endfunction
endpackage

// File: rtl/sss_seed_bank.sv
`timescale 1ns/1ps
module sss_seed_bank
  import sss_pkg::*;
#(
  parameter state_t LONG_RST  = 7'h6C,
  parameter state_t SHORT_RST = 7'h1B
)(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bank_sel,
  input  logic   wr_en,
  input  state_t wr_data,
  output state_t long_q_o,
  output state_t short_q_o
);
  state_t long_q;
  state_t short_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      long_q  <= LONG_RST;
      short_q <= SHORT_RST;
    end else if (wr_en) begin
      if (bank_sel) short_q <= wr_data;
      else          long_q  <= wr_data;
    end
  end

  assign long_q_o  = long_q;
  assign short_q_o = short_q;
endmodule

// File: rtl/sss_lfsr_core.sv
`timescale 1ns/1ps
module sss_lfsr_core
  import sss_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  state_t seed,
  input  logic   step,
  input  dir_e   dir,
  input  logic   din,
  output state_t base_state,
  output logic   dout,
  output logic   shift_bit
);
  state_t state_q;

  always_comb begin
    base_state = load ? seed : state_q;
    dout       = din ^ key_bit(base_state);
    shift_bit  = (dir == DIR_RX) ? din : dout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= '0;
    else if (step) state_q <= push(base_state, shift_bit);
    else if (load) state_q <= seed;
  end
endmodule

// File: rtl/sss_lock_detect.sv
`timescale 1ns/1ps
module sss_lock_detect
  import sss_pkg::*;
#(
  parameter int LOCK_RUN = 64
)(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear,
  input  logic   step,
  input  logic   new_bit,
  input  state_t hist,
  output logic   locked
);
  localparam int CW = $clog2(LOCK_RUN + 1);

  logic [NUM_PER-1:0] hit;

  for (genvar g = 0; g < NUM_PER; g++) begin : g_per
    localparam int P = PERIODS[g];
    logic [CW-1:0] run_q;
    logic [CW-1:0] run_base;
    logic          same;

    assign same     = (new_bit == hist[P-1]);
    assign run_base = clear ? '0 : run_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        run_q <= '0;
      else if (step)
        run_q <= !same ? '0 :
                 (run_base == CW'(LOCK_RUN)) ? run_base : run_base + CW'(1);
      else if (clear)
        run_q <= '0;
    end

    assign hit[g] = (run_q == CW'(LOCK_RUN));
  end

  logic unused_hist;
  assign unused_hist = ^hist;

  assign locked = |hit;
endmodule

// File: rtl/selfsync_scrambler.sv
`timescale 1ns/1ps
module selfsync_scrambler
  import sss_pkg::*;
#(
  parameter int     LOCK_RUN       = 64,
  parameter state_t LONG_SEED_RST  = 7'h6C,
  parameter state_t SHORT_SEED_RST = 7'h1B
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_rx,
  input  logic              frame_start,
  input  logic              short_pre,
  input  logic              bank_sel,
  input  logic              seed_we,
  input  logic [STAGES-1:0] seed_wdata,
  output logic [STAGES-1:0] seed_rdata,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              out_valid,
  output logic              out_bit,
  output logic              lock_flag
);
  state_t long_seed_w;
  state_t short_seed_w;
  state_t load_seed_w;
  state_t base_w;
  dir_e   dir_w;
  logic   dout_w;
  logic   shift_w;
  logic   out_valid_q;
  logic   out_bit_q;

  sss_seed_bank #(
    .LONG_RST  (LONG_SEED_RST),
    .SHORT_RST (SHORT_SEED_RST)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_sel  (bank_sel),
    .wr_en     (seed_we),
    .wr_data   (seed_wdata),
    .long_q_o  (long_seed_w),
    .short_q_o (short_seed_w)
  );

  assign seed_rdata  = bank_sel  ? short_seed_w : long_seed_w;
  assign load_seed_w = short_pre ? short_seed_w : long_seed_w;
  assign dir_w       = mode_rx   ? DIR_RX : DIR_TX;

  sss_lfsr_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (frame_start),
    .seed       (load_seed_w),
    .step       (in_valid),
    .dir        (dir_w),
    .din        (in_bit),
    .base_state (base_w),
    .dout       (dout_w),
    .shift_bit  (shift_w)
  );

  sss_lock_detect #(
    .LOCK_RUN (LOCK_RUN)
  ) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (frame_start),
    .step    (in_valid),
    .new_bit (shift_w),
    .hist    (base_w),
    .locked  (lock_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_bit_q   <= 1'b0;
    end else begin
      out_valid_q <= in_valid;
      if (in_valid) out_bit_q <= dout_w;
    end
  end

  assign out_valid = out_valid_q;
  assign out_bit   = out_bit_q;
endmodule

// File: rtl/selfsync_scrambler_chk.sv
`timescale 1ns/1ps
module selfsync_scrambler_chk
  import sss_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   mode_rx,
  input logic   frame_start,
  input logic   bank_sel,
  input logic   seed_we,
  input state_t seed_wdata,
  input logic   in_valid,
  input logic   in_bit,
  input logic   out_valid,
  input logic   out_bit,
  input logic   lock_flag,
  input state_t long_seed_w,
  input state_t short_seed_w,
  input state_t load_seed_w,
  input state_t base_w
);
  p_tx_feedback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !mode_rx |=> frame_start || (base_w[0] == out_bit));

  p_rx_feedback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode_rx |=> frame_start || (base_w[0] == $past(in_bit)));

  p_valid_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !frame_start |=> frame_start || $stable(base_w));

  p_bank_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seed_we |=> (($past(bank_sel) ? short_seed_w : long_seed_w) == $past(seed_wdata)));

  p_short_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seed_we && !bank_sel |=> $stable(short_seed_w));

  p_long_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seed_we && bank_sel |=> $stable(long_seed_w));

  p_seed_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !in_valid |=> frame_start || (base_w == $past(load_seed_w)));

  p_lock_needs_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_flag) |-> $past(in_valid));

  p_lock_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !in_valid |=> !lock_flag);
endmodule

bind selfsync_scrambler selfsync_scrambler_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_rx      (mode_rx),
  .frame_start  (frame_start),
  .bank_sel     (bank_sel),
  .seed_we      (seed_we),
  .seed_wdata   (seed_wdata),
  .in_valid     (in_valid),
  .in_bit       (in_bit),
  .out_valid    (out_valid),
  .out_bit      (out_bit),
  .lock_flag    (lock_flag),
  .long_seed_w  (long_seed_w),
  .short_seed_w (short_seed_w),
  .load_seed_w  (load_seed_w),
  .base_w       (base_w)
);

// File: tb/selfsync_scrambler_test.sv
`timescale 1ns/1ps
module selfsync_scrambler_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_rx = 1'b0;
  logic       frame_start = 1'b0;
  logic       short_pre = 1'b0;
  logic       bank_sel = 1'b0;
  logic       seed_we = 1'b0;
  logic [6:0] seed_wdata = '0;
  logic [6:0] seed_rdata;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       out_valid;
  logic       out_bit;
  logic       lock_flag;

  int checks = 0;
  int errors = 0;

  // bench reference line: m[1] newest .. m[7] oldest
  logic [1:7]  m;
  logic [15:0] prbs = 16'hACE1;

  always #5 clk = ~clk;

  selfsync_scrambler uut (
    .clk(clk), .rst_n(rst_n), .mode_rx(mode_rx), .frame_start(frame_start),
    .short_pre(short_pre), .bank_sel(bank_sel), .seed_we(seed_we),
    .seed_wdata(seed_wdata), .seed_rdata(seed_rdata), .in_valid(in_valid),
    .in_bit(in_bit), .out_valid(out_valid), .out_bit(out_bit), .lock_flag(lock_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic next_data();
    prbs = {prbs[14:0], prbs[15] ^ prbs[14] ^ prbs[12] ^ prbs[3]};
    return prbs[0];
  endfunction

  task automatic model_load(input logic [6:0] seed);
    for (int k = 0; k < 7; k++) m[k+1] = seed[k];
  endtask

  // returns the expected output and advances the reference line
  function automatic logic model_step(input logic b, input logic rx);
    logic o;
    o = b ^ m[4] ^ m[7];
    m = {(rx ? b : o), m[1:6]};
    return o;
  endfunction

  task automatic send(input logic b);
    in_bit = b;
    in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic wseed(input logic bank, input logic [6:0] val);
    bank_sel = bank; seed_we = 1'b1; seed_wdata = val;
    @(posedge clk); #1;
    seed_we = 1'b0;
  endtask

  task automatic frame(input logic sp);
    short_pre = sp; frame_start = 1'b1;
    @(posedge clk); #1;
    frame_start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 out_valid", out_valid, 0);
    chk("R10 out_bit", out_bit, 0);
    chk("R10 lock_flag", lock_flag, 0);
    bank_sel = 1'b0; #1;
    chk("R5 long reset seed", seed_rdata, 7'h6C);
    bank_sel = 1'b1; #1;
    chk("R5 short reset seed", seed_rdata, 7'h1B);
  endtask

  task automatic t_seed_bank();
    wseed(1'b0, 7'h55);
    chk("R5 long readback", seed_rdata, 7'h55);
    bank_sel = 1'b1; #1;
    chk("R4 short untouched", seed_rdata, 7'h1B);
    wseed(1'b1, 7'h2A);
    chk("R5 short readback", seed_rdata, 7'h2A);
    bank_sel = 1'b0; #1;
    chk("R4 long untouched", seed_rdata, 7'h55);
  endtask

  task automatic t_tx(input logic sp);
    logic e;
    mode_rx = 1'b0;
    frame(sp);
    model_load(sp ? 7'h2A : 7'h55);
    for (int i = 0; i < 24; i++) begin
      logic d;
      d = next_data();
      e = model_step(d, 1'b0);
      send(d);
      chk(sp ? "R6 R1 tx short seed" : "R6 R1 tx long seed", out_bit, e);
      chk("R3 out_valid", out_valid, 1);
    end
  endtask

  task automatic t_rx_sync();
    logic [1:7] tx_line;
    logic s;
    mode_rx = 1'b1;
    frame(1'b0);
    tx_line = {7'h33};
    for (int i = 0; i < 40; i++) begin
      logic d;
      d = next_data();
      s = d ^ tx_line[4] ^ tx_line[7];
      tx_line = {s, tx_line[1:6]};
      send(s);
      if (i >= 7) chk("R2 rx recovers data", out_bit, d);
    end
  endtask

  task automatic t_idle_gap();
    logic e;
    mode_rx = 1'b0;
    frame(1'b0);
    model_load(7'h55);
    for (int i = 0; i < 5; i++) begin
      logic d;
      d = next_data(); e = model_step(d, 1'b0); send(d);
      chk("R1 before gap", out_bit, e);
    end
    for (int i = 0; i < 4; i++) begin
      in_bit = ~in_bit;
      @(posedge clk); #1;
      chk("R3 idle out_valid low", out_valid, 0);
    end
    for (int i = 0; i < 5; i++) begin
      logic d;
      d = next_data(); e = model_step(d, 1'b0); send(d);
      chk("R3 state held over gap", out_bit, e);
    end
  endtask

  task automatic t_same_cycle();
    logic e;
    mode_rx = 1'b0;
    wseed(1'b1, 7'h08);
    model_load(7'h08);
    e = model_step(1'b0, 1'b0);
    short_pre = 1'b1; frame_start = 1'b1; in_bit = 1'b0; in_valid = 1'b1;
    @(posedge clk); #1;
    frame_start = 1'b0; in_valid = 1'b0;
    chk("R7 bit uses fresh seed", out_bit, 1);
    chk("R7 model agrees", e, 1);
    for (int i = 0; i < 6; i++) begin
      logic d;
      d = next_data(); e = model_step(d, 1'b0); send(d);
      chk("R7 continues after load", out_bit, e);
    end
  endtask

  task automatic t_lock_boundary();
    mode_rx = 1'b1;
    wseed(1'b0, 7'h7F);
    frame(1'b0);
    for (int i = 0; i < 63; i++) send(1'b1);
    chk("R8 no lock at 63", lock_flag, 0);
    send(1'b1);
    chk("R8 lock at 64", lock_flag, 1);
    send(1'b0);
    chk("R8 mismatch clears", lock_flag, 0);
  endtask

  task automatic t_lock_tx_zero();
    mode_rx = 1'b0;
    wseed(1'b0, 7'h00);
    frame(1'b0);
    for (int i = 0; i < 63; i++) send(1'b0);
    chk("R8 tx zeros no lock at 63", lock_flag, 0);
    chk("R1 zero line passes zeros", out_bit, 0);
    send(1'b0);
    chk("R8 tx zeros lock at 64", lock_flag, 1);
    frame(1'b0);
    chk("R9 frame_start clears lock", lock_flag, 0);
  endtask

  task automatic t_lock_patterns();
    mode_rx = 1'b1;
    for (int p = 0; p < 3; p++) begin
      int n;
      frame(1'b0);
      for (int i = 0; i < 80; i++) begin
        logic b;
        b = (p == 0) ? (i % 2 == 0) : (p == 1) ? ((i % 4) < 2) : ((i % 6) < 3);
        send(b);
        if (i == 59) chk("R8 pattern below run", lock_flag, 0);
      end
      n = p;
      chk(n == 0 ? "R8 lock on 10" : n == 1 ? "R8 lock on 1100" : "R8 lock on 111000",
          lock_flag, 1);
    end
  endtask

  task automatic t_lock_random();
    int seen;
    seen = 0;
    mode_rx = 1'b1;
    frame(1'b0);
    for (int i = 0; i < 200; i++) begin
      send(next_data());
      if (lock_flag) seen++;
    end
    chk("R8 random data no lock", seen, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_seed_bank();
    t_tx(1'b0);
    t_tx(1'b1);
    t_rx_sync();
    t_idle_gap();
    t_same_cycle();
    t_lock_boundary();
    t_lock_tx_zero();
    t_lock_patterns();
    t_lock_random();
    finish_run();
  end
endmodule